// File: doc/BRIEF.md
# PCM Clock Generator with Control Register

This block pairs a byte-wide control register on a simple processor read/write bus with a generator for a PCM bit clock and an 8 kHz frame strobe. The register has three parts. It shows the processor clock rate set on two strap pins, it picks one of three PCM bit clock rates, and it selects whether the block is the timing master or a slave.

As master, the block divides a 16.384 MHz reference (its own clock) by 2, 4 or 8 to make the bit clock. It also makes a frame strobe that is one bit-clock period wide and repeats every 2048 reference cycles. These two signals go to a pair of tri-state pads. The pads are enabled only after software has written the register at least once, and only while master is selected. As slave, the pads stay disabled, and the clock and strobe arriving on the pads are passed to the internal outputs.

The bus is synchronous to the reference clock. Writes and reads take one cycle each. Read data is combinational.

Top module: `pcm_clkgen_ctl`

## Requirements
- R1: After reset, a read of the register returns 0x10 with bits 1..0 equal to the synchronised strap pins, and the pad enable is low.
- R2: A read at address 0x360 returns {3'b000, master bit (bit 4), rate code (bits 3..2), synchronised straps (bits 1..0)} in the same cycle. Bits 7..5 are always zero.
- R3: Bits 1..0 follow the strap pins through two flip-flops. A write to those bit positions has no effect.
- R4: A read at any address other than 0x360 returns 0x00.
- R5: The pad enable is low until the first write to 0x360. After that write, it equals the master bit (1 = master, 0 = slave).
- R6: While the master bit is 0, the pad enable is low and the internal clock and strobe outputs equal the pad inputs.
- R7: Rate codes 00, 01 and 10 divide the reference by 2, 4 and 8. The bit clock is high for the first half of each period and low for the second half.
- R8: A write of rate code 11 keeps the previous rate, both in the read-back and in the divider. The master bit in the same write still takes effect.
- R9: The frame strobe is high for exactly one bit-clock period every 2048 reference cycles. That is 1024, 512 or 256 bit-clock periods for codes 00, 01 and 10.
- R10: One cycle after the stored rate code changes, the divider and the frame counter restart together. The bit clock and the strobe then both begin high.
- R11: A write to any other address changes neither the register nor the written-once state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz reference and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 12 | Bus address |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, zero when not selected |
| speed_strap | input | 2 | Processor clock rate strap pins |
| pdc_pad_i | input | 1 | Bit clock arriving on the pad (slave) |
| pfs_pad_i | input | 1 | Frame strobe arriving on the pad (slave) |
| pdc_pad_o | output | 1 | Generated bit clock towards the pad |
| pfs_pad_o | output | 1 | Generated frame strobe towards the pad |
| pcm_pad_oe | output | 1 | Output enable for both pads |
| pcm_clk_o | output | 1 | Internal bit clock (generated or external) |
| pcm_fsync_o | output | 1 | Internal frame strobe (generated or external) |

## Verification
The assertions assume that bus inputs are stable around each clock edge and that a write strobe lasts exactly one cycle. They also assume the strap pins change slowly compared with the two-flop synchroniser. The stimulus changes every input a fixed time after the rising edge. It pulses write for one cycle and changes the straps only during long idle stretches. Pad inputs are toggled freely, but only their pass-through in slave mode is checked.

// File: rtl/pcm_clkgen_pkg.sv
package pcm_clkgen_pkg;

  typedef enum logic [1:0] {
    RATE_DIV2 = 2'b00,
    RATE_DIV4 = 2'b01,
    RATE_DIV8 = 2'b10,
    RATE_RSVD = 2'b11
  } pdc_rate_e;

  typedef struct packed {
    logic [2:0] spare;
    logic       master;
    pdc_rate_e  rate;
    logic [1:0] cpu_speed;
  } ctl_word_t;

  localparam int unsigned DIV_MAX = 8;

  function automatic int unsigned rate_div(pdc_rate_e r);
    case (r)
      RATE_DIV2: return 2;
      RATE_DIV4: return 4;
      RATE_DIV8: return 8;
      default:   return 2;
    endcase
  endfunction

  function automatic logic rate_usable(logic [1:0] code);
    return code != 2'b11;
  endfunction

  function automatic int unsigned frame_pdc_cycles(int unsigned ref_per_frame, pdc_rate_e r);
    return ref_per_frame / rate_div(r);
  endfunction

endpackage

// File: rtl/pcm_ctl_reg.sv
module pcm_ctl_reg
  import pcm_clkgen_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [11:0] REG_ADDR = 12'h360
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        cpu_wdata,
  input  logic [1:0]        speed_strap,
  output logic [7:0]        cpu_rdata,
  output logic              cfg_master,
  output pdc_rate_e         cfg_rate,
  output logic              wr_seen
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic       addr_hit;
  logic       wr_hit;
  logic       rd_hit;
  logic [1:0] strap_s1;
  logic [1:0] strap_s2;
  logic       master_q;
  pdc_rate_e  rate_q;
  logic       seen_q;
  ctl_word_t  rd_word;
  logic       unused_wbits;

  assign addr_hit     = (cpu_addr == HIT_ADDR);
  assign wr_hit       = cpu_wr && addr_hit;
  assign rd_hit       = cpu_rd && addr_hit;
  assign unused_wbits = ^{cpu_wdata[7:5], cpu_wdata[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_s1 <= 2'b00;
      strap_s2 <= 2'b00;
    end else begin
      strap_s1 <= speed_strap;
      strap_s2 <= strap_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b1;
      rate_q   <= RATE_DIV2;
      seen_q   <= 1'b0;
    end else if (wr_hit) begin
      master_q <= cpu_wdata[4];
      if (rate_usable(cpu_wdata[3:2])) begin
        rate_q <= pdc_rate_e'(cpu_wdata[3:2]);
      end
      seen_q <= 1'b1;
    end
  end

  always_comb begin
    rd_word           = '0;
    rd_word.master    = master_q;
    rd_word.rate      = rate_q;
    rd_word.cpu_speed = strap_s2;
  end

  assign cpu_rdata  = rd_hit ? rd_word : 8'h00;
  assign cfg_master = master_q;
  assign cfg_rate   = rate_q;
  assign wr_seen    = seen_q;

  // R2: upper bits never carry data
  p_top_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[7:5] == 3'b000);

  // R5: the written-once flag rises only as a result of a register write
  p_seen_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seen_q) |-> $past(wr_hit));

  // R8: reserved rate code leaves the stored rate alone
  p_reserved_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && cpu_wdata[3:2] == 2'b11) |=> (rate_q == $past(rate_q)));

  // R11: foreign writes do not touch the register
  p_foreign_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !addr_hit) |=> ($stable(master_q) && $stable(rate_q) && $stable(seen_q)));

endmodule

// File: rtl/pcm_bit_divider.sv
module pcm_bit_divider
  import pcm_clkgen_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pdc_rate_e cfg_rate,
  output pdc_rate_e cur_rate,
  output logic      rate_restart,
  output logic      pdc_wrap,
  output logic      pdc_gen
);

  localparam int unsigned CNT_W = $clog2(DIV_MAX);

  pdc_rate_e        act_q;
  logic [CNT_W-1:0] div_cnt;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] half_cnt;

  assign last_cnt     = CNT_W'(rate_div(act_q) - 1);
  assign half_cnt     = CNT_W'(rate_div(act_q) / 2);
  assign rate_restart = (cfg_rate != act_q);
  assign pdc_wrap     = !rate_restart && (div_cnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= RATE_DIV2;
      div_cnt <= '0;
    end else if (rate_restart) begin
      act_q   <= cfg_rate;
      div_cnt <= '0;
    end else if (div_cnt == last_cnt) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign pdc_gen  = (div_cnt < half_cnt);
  assign cur_rate = act_q;

  // R7: the phase counter never leaves the active period
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(div_cnt) < rate_div(act_q));

  // R10: a rate change starts a fresh, high, bit-clock period
  p_restart_fresh_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rate_restart |=> (pdc_gen && div_cnt == '0));

endmodule

// File: rtl/pcm_frame_gen.sv
module pcm_frame_gen
  import pcm_clkgen_pkg::*;
#(
  parameter int unsigned REF_PER_FRAME = 2048
) (
  input  logic      clk,
  input  logic      rst_n,
  input  pdc_rate_e cur_rate,
  input  logic      rate_restart,
  input  logic      pdc_wrap,
  output logic      pfs_gen
);

  localparam int unsigned FCNT_W = $clog2(REF_PER_FRAME / 2);

  logic [FCNT_W-1:0] fcnt;
  logic [FCNT_W-1:0] flast;

  assign flast = FCNT_W'(frame_pdc_cycles(REF_PER_FRAME, cur_rate) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
    end else if (rate_restart) begin
      fcnt <= '0;
    end else if (pdc_wrap) begin
      fcnt <= (fcnt == flast) ? '0 : fcnt + 1'b1;
    end
  end

  assign pfs_gen = (fcnt == '0);

  // R9: the strobe lasts exactly one bit-clock period
  p_pfs_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pfs_gen && pdc_wrap) |=> !pfs_gen);

  // R10: the frame restarts with the divider
  p_frame_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rate_restart |=> pfs_gen);

endmodule

// File: rtl/pcm_clkgen_ctl.sv
module pcm_clkgen_ctl
  import pcm_clkgen_pkg::*;
#(
  parameter int unsigned ADDR_W        = 12,
  parameter logic [11:0] REG_ADDR      = 12'h360,
  parameter int unsigned REF_PER_FRAME = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic [1:0]        speed_strap,
  input  logic              pdc_pad_i,
  input  logic              pfs_pad_i,
  output logic              pdc_pad_o,
  output logic              pfs_pad_o,
  output logic              pcm_pad_oe,
  output logic              pcm_clk_o,
  output logic              pcm_fsync_o
);

  logic      cfg_master;
  pdc_rate_e cfg_rate;
  pdc_rate_e cur_rate;
  logic      wr_seen;
  logic      rate_restart;
  logic      pdc_wrap;
  logic      pdc_gen;
  logic      pfs_gen;

  pcm_ctl_reg #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
  ) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wr     (cpu_wr),
    .cpu_rd     (cpu_rd),
    .cpu_wdata  (cpu_wdata),
    .speed_strap(speed_strap),
    .cpu_rdata  (cpu_rdata),
    .cfg_master (cfg_master),
    .cfg_rate   (cfg_rate),
    .wr_seen    (wr_seen)
  );

  pcm_bit_divider u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rate    (cfg_rate),
    .cur_rate    (cur_rate),
    .rate_restart(rate_restart),
    .pdc_wrap    (pdc_wrap),
    .pdc_gen     (pdc_gen)
  );

  pcm_frame_gen #(
    .REF_PER_FRAME(REF_PER_FRAME)
  ) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur_rate    (cur_rate),
    .rate_restart(rate_restart),
    .pdc_wrap    (pdc_wrap),
    .pfs_gen     (pfs_gen)
  );

  assign pdc_pad_o   = pdc_gen;
  assign pfs_pad_o   = pfs_gen;
  assign pcm_pad_oe  = wr_seen && cfg_master;
  assign pcm_clk_o   = cfg_master ? pdc_gen : pdc_pad_i;
  assign pcm_fsync_o = cfg_master ? pfs_gen : pfs_pad_i;

  // R6: slave mode never drives the pads
  p_slave_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> !pcm_pad_oe);

  // R5: no pad drive before the first register write
  p_oe_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_pad_oe |-> wr_seen);

endmodule

// File: tb/test_pcm_clkgen_ctl.sv
`timescale 1ns/1ps
module test_pcm_clkgen_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic [1:0]  speed_strap = 2'b10;
  logic        pdc_pad_i = 1'b0;
  logic        pfs_pad_i = 1'b0;
  logic        pdc_pad_o, pfs_pad_o, pcm_pad_oe, pcm_clk_o, pcm_fsync_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  pcm_clkgen_ctl i_pcm_clkgen_ctl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .speed_strap(speed_strap),
    .pdc_pad_i(pdc_pad_i), .pfs_pad_i(pfs_pad_i), .pdc_pad_o(pdc_pad_o),
    .pfs_pad_o(pfs_pad_o), .pcm_pad_oe(pcm_pad_oe), .pcm_clk_o(pcm_clk_o),
    .pcm_fsync_o(pcm_fsync_o)
  );

  // behavioural reference: phase since last restart, in reference cycles
  int   m_phase;
  int   m_act;
  int   m_rate;
  bit   m_ms;
  bit   m_written;
  logic [1:0] m_s1, m_s2;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_act = 0; m_rate = 0; m_ms = 1; m_written = 0;
      m_s1 = 2'b00; m_s2 = 2'b00;
    end else begin
      if (m_act != m_rate) begin
        m_act = m_rate;
        m_phase = 0;
      end else begin
        m_phase = (m_phase + 1) % 2048;
      end
      m_s2 = m_s1;
      m_s1 = speed_strap;
      if (cpu_wr && cpu_addr == 12'h360) begin
        m_ms = cpu_wdata[4];
        if (cpu_wdata[3:2] != 2'b11) m_rate = int'(cpu_wdata[3:2]);
        m_written = 1;
      end
    end
  end

  function automatic int div_of(int code);
    return 2 << code;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic int  d       = div_of(m_act);
      automatic bit  gen_pdc = (m_phase % d) < (d / 2);
      automatic bit  gen_pfs = m_phase < d;
      automatic int  exp_rd  = (cpu_rd && cpu_addr == 12'h360) ?
                               {3'b000, m_ms, m_rate[1:0], m_s2} : 0;
      chk("R2 read data", cpu_rdata, exp_rd);
      chk("R5 pad enable", pcm_pad_oe, m_written && m_ms);
      chk("R7 pad clock", pdc_pad_o, gen_pdc);
      chk("R9 pad strobe", pfs_pad_o, gen_pfs);
      if (m_ms) begin
        chk("R7 internal clock", pcm_clk_o, gen_pdc);
        chk("R9 internal strobe", pcm_fsync_o, gen_pfs);
      end else begin
        chk("R6 clock pass-through", pcm_clk_o, pdc_pad_i);
        chk("R6 strobe pass-through", pcm_fsync_o, pfs_pad_i);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      cpu_wr = 0; cpu_rd = 0;
    end
  endtask

  task automatic do_write(logic [11:0] a, logic [7:0] d);
    @(posedge clk); #2;
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1; cpu_rd = 0;
    @(posedge clk); #2;
    cpu_wr = 0;
  endtask

  task automatic do_read(logic [11:0] a, logic [7:0] exp, string tag);
    @(posedge clk); #2;
    cpu_addr = a; cpu_rd = 1; cpu_wr = 0;
    @(negedge clk);
    chk(tag, cpu_rdata, exp);
    @(posedge clk); #2;
    cpu_rd = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1;
    idle(4);
    // R1: reset value with straps 10
    do_read(12'h360, 8'h12, "R1 reset value");
    chk("R1 pad enable after reset", pcm_pad_oe, 0);
    idle(3000);
    // R4: other addresses read as zero
    do_read(12'h361, 8'h00, "R4 foreign read");
    do_read(12'h060, 8'h00, "R4 foreign read low");
    // R11: foreign write changes nothing
    do_write(12'h260, 8'h0C);
    idle(2);
    chk("R11 pads stay off", pcm_pad_oe, 0);
    do_read(12'h360, 8'h12, "R11 register unchanged");
    // R3 and R8: strap bits and reserved code ignored, master kept
    do_write(12'h360, 8'hFF);
    idle(1);
    do_read(12'h360, 8'h12, "R3 R8 read-back after 0xFF");
    chk("R5 pads on after first write", pcm_pad_oe, 1);
    idle(2500);
    // R10: change to divide-by-4 restarts clock and strobe high
    do_write(12'h360, 8'h14);
    @(posedge clk); @(negedge clk);
    chk("R10 clock high after restart", pcm_clk_o, 1);
    chk("R10 strobe high after restart", pcm_fsync_o, 1);
    idle(4500);
    do_write(12'h360, 8'h18);
    idle(2000);
    speed_strap = 2'b01;
    idle(2500);
    do_read(12'h360, 8'h19, "R3 new strap value");
    do_write(12'h360, 8'h1C);
    idle(300);
    do_read(12'h360, 8'h19, "R8 reserved keeps divide-by-8");
    // R6: slave mode
    do_write(12'h360, 8'h04);
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #2;
      pdc_pad_i = i[0];
      pfs_pad_i = (i % 37) == 0;
    end
    chk("R6 pads off in slave", pcm_pad_oe, 0);
    do_write(12'h360, 8'h10);
    idle(2500);
    idle(7);
    do_write(12'h360, 8'h14);
    idle(1500);
    // R1: reset again mid-run returns pads to off
    @(posedge clk); #2 rst_n = 0;
    @(posedge clk); #2 rst_n = 1;
    @(negedge clk);
    chk("R1 pads off after second reset", pcm_pad_oe, 0);
    idle(3000);
    finish_run();
  end

endmodule